// File: doc/BRIEF.md
# Gate Drive Propagation Delay Regulator

This is a digital controller for one half-bridge gate driver. Each command edge starts a turn-on or a turn-off event. For each event the block times two phases: a pre-charge (or pre-discharge) window, then an optional post-charge wait. Together the two phases span a programmed target delay. All timing is counted in ticks of an external 140 ns strobe. The target delay is a 6-bit tick count.

The block keeps a separate gate-current code for the charge direction and for the discharge direction. After each event the measurement logic returns the switching delay it saw, as a tick count. When the loop is enabled, the block adds a proportional correction to the current code of the direction that just switched. That correction is the gain times the delay error, where the error is either clamped to one step or used at full size. The result saturates between the lowest step and a programmable ceiling. When the loop is disabled, the initial code of each direction drives the output.

The current code is linear, in units of 4 mA. Code 1 is 4 mA and code 16 is 64 mA.

Top module: `gdr_delay_reg`

## Requirements
- R1: After reset the outputs are as follows: `phase_o` is 00 (idle), `dir_o` is 1 (charge), and `idrv_o` equals the decoded initial charge code.
- R2: On a command edge `phase_o` becomes 01 (pre window). It stays 01 for P = floor((f+1)*T/8) ticks, where T is `tgt_dly_i` and f is the 2-bit window select of the commanded direction. If P is 0, the pre window is skipped.
- R3: When `post_en_i` is 1 and T > P, phase 10 (post wait) follows the pre window for T-P ticks, and the phase then returns to 00. When `post_en_i` is 0, the phase goes to 00 straight after the pre window.
- R4: A command edge that arrives while an event is running restarts the sequence from the start of the pre window, with the direction of the new command.
- R5: Cycles without `tick_i` and without a command leave `phase_o` unchanged. The value 11 never appears on `phase_o`.
- R6: `cmd_on_i` sets `dir_o` to 1. `cmd_off_i` alone sets `dir_o` to 0. If both are high, `cmd_on_i` wins. `idrv_o` shows the code of the direction given by `dir_o`.
- R7: An initial-code select s decodes to code 1<<s (4, 8, 16 or 32 mA). The reset selects are 1 (charge) and 2 (discharge).
- R8: While `loop_en_i` is 0, each direction's code is held at its initial value and `meas_vld_i` has no effect on `idrv_o`.
- R9: On `meas_vld_i` with the loop enabled, the error is e = `meas_dly_i` - T. With `err_full_i` at 0, the code of `dir_o` changes by g*sign(e).
- R10: With `err_full_i` at 1, the code changes by g*e.
- R11: The gain select g_s maps to gain g = g_s+1.
- R12: The ceiling select c maps to ceiling 16>>c. `idrv_o` never exceeds the ceiling, even when the initial code is larger, and it never drops below 1. Adapted codes saturate at both limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 140 ns timebase strobe |
| cmd_on_i | input | 1 | Turn-on command edge (pulse) |
| cmd_off_i | input | 1 | Turn-off command edge (pulse) |
| tgt_dly_i | input | 6 | Target delay T in ticks |
| pre_chg_sel_i | input | 2 | Pre-charge window fraction select |
| pre_dis_sel_i | input | 2 | Pre-discharge window fraction select |
| post_en_i | input | 1 | Enable post-charge wait |
| init_chg_sel_i | input | 2 | Initial charge current select |
| init_dis_sel_i | input | 2 | Initial discharge current select |
| ceil_sel_i | input | 2 | Current ceiling select |
| gain_sel_i | input | 2 | Proportional gain select |
| err_full_i | input | 1 | 1 = full error, 0 = error clamped to one step |
| loop_en_i | input | 1 | Enable delay adaptation |
| meas_vld_i | input | 1 | Measured delay sample valid |
| meas_dly_i | input | 8 | Measured switching delay in ticks |
| phase_o | output | 2 | 00 idle, 01 pre window, 10 post wait |
| dir_o | output | 1 | Direction of the last command, 1 = charge |
| idrv_o | output | 5 | Gate current code in 4 mA units |

## Verification
The assertions check the following on every cycle:
- the code on `idrv_o` stays between 1 and the ceiling;
- the phase encoding is legal and the phase holds still between ticks;
- the command-to-direction mapping is correct;
- in clamped-error mode, a single sample never moves the code by more than the gain.

The window lengths and the post-wait lengths for each fraction select can only be shown by the bench's scenarios. The same holds for the restart on a mid-event command, the exact corrections in clamped and full-error modes, saturation at both ends, the separate codes kept for each direction, and the loop-disabled hold. In each case the bench compares against values it works out from T and the field codes.

// File: rtl/gdr_pkg.sv
package gdr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_PRE  = 2'b01,
    PH_POST = 2'b10
  } phase_e;

  localparam int unsigned SEL_W = 2;
  localparam int unsigned NDIR  = 2;  // index 0 discharge, 1 charge
endpackage

// File: rtl/gdr_phase_seq.sv
module gdr_phase_seq
  import gdr_pkg::*;
#(
  parameter int unsigned TGT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [SEL_W-1:0] frac_i,
  input  logic             post_en_i,
  output phase_e           phase_o
);
  localparam int unsigned PW = TGT_W + 3;

  logic [PW-1:0]    scaled;
  logic [TGT_W-1:0] pre_len, post_len;
  logic [TGT_W-1:0] cnt_q;
  logic [TGT_W:0]   cnt_inc;
  phase_e           phase_q, after_pre;

  // window = (f+1)/8 of target, rounded down
  always_comb begin
    scaled    = ({{(PW-SEL_W){1'b0}}, frac_i} + PW'(1)) * {3'b000, tgt_i};
    pre_len   = TGT_W'(scaled >> 3);
    post_len  = tgt_i - pre_len;
    cnt_inc   = {1'b0, cnt_q} + (TGT_W+1)'(1);
    after_pre = (post_en_i && (post_len != '0)) ? PH_POST : PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      cnt_q   <= '0;
      phase_q <= (pre_len != '0) ? PH_PRE : after_pre;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_PRE: begin
          if (cnt_inc >= {1'b0, pre_len}) begin
            cnt_q   <= '0;
            phase_q <= after_pre;
          end else begin
            cnt_q <= cnt_inc[TGT_W-1:0];
          end
        end
        PH_POST: begin
          if (cnt_inc >= {1'b0, post_len}) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_inc[TGT_W-1:0];
          end
        end
        default: cnt_q <= '0;
      endcase
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gdr_code_adapt.sv
module gdr_code_adapt #(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned ERR_W    = 10,
  parameter int unsigned RST_CODE = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    loop_en_i,
  input  logic                    upd_i,
  input  logic                    full_i,
  input  logic [2:0]              gain_i,
  input  logic [CODE_W-1:0]       init_i,
  input  logic [CODE_W-1:0]       ceil_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [CODE_W-1:0]       code_o
);
  localparam int unsigned ADJ_W = ERR_W + 4;

  logic [CODE_W-1:0]       code_q, code_nxt;
  logic signed [ADJ_W-1:0] e_ext, prod, sum, ceil_s;

  always_comb begin
    if (full_i)           e_ext = ADJ_W'(err_i);
    else if (err_i > 0)   e_ext = ADJ_W'(1);
    else if (err_i < 0)   e_ext = -ADJ_W'(1);
    else                  e_ext = '0;
    prod   = e_ext * $signed({{(ADJ_W-3){1'b0}}, gain_i});
    sum    = $signed({{(ADJ_W-CODE_W){1'b0}}, code_q}) + prod;
    ceil_s = $signed({{(ADJ_W-CODE_W){1'b0}}, ceil_i});
    if (sum > ceil_s)           code_nxt = ceil_i;
    else if (sum < ADJ_W'(1))   code_nxt = CODE_W'(1);
    else                        code_nxt = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         code_q <= CODE_W'(RST_CODE);
    else if (!loop_en_i) code_q <= init_i;
    else if (upd_i)      code_q <= code_nxt;
  end

  assign code_o = code_q;
endmodule

// File: rtl/gdr_delay_reg.sv
module gdr_delay_reg
  import gdr_pkg::*;
#(
  parameter int unsigned TGT_W  = 6,
  parameter int unsigned MEAS_W = 8,
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_on_i,
  input  logic              cmd_off_i,
  input  logic [TGT_W-1:0]  tgt_dly_i,
  input  logic [1:0]        pre_chg_sel_i,
  input  logic [1:0]        pre_dis_sel_i,
  input  logic              post_en_i,
  input  logic [1:0]        init_chg_sel_i,
  input  logic [1:0]        init_dis_sel_i,
  input  logic [1:0]        ceil_sel_i,
  input  logic [1:0]        gain_sel_i,
  input  logic              err_full_i,
  input  logic              loop_en_i,
  input  logic              meas_vld_i,
  input  logic [MEAS_W-1:0] meas_dly_i,
  output logic [1:0]        phase_o,
  output logic              dir_o,
  output logic [CODE_W-1:0] idrv_o
);
  localparam int unsigned ERR_W    = MEAS_W + 2;
  localparam int unsigned CODE_TOP = 1 << (CODE_W - 1);

  logic                    dir_q, start, dir_eff;
  logic [1:0]              frac_sel;
  logic [CODE_W-1:0]       ceil_code, raw_code;
  logic [2:0]              gain;
  logic signed [ERR_W-1:0] err;
  logic [1:0]              init_sel [NDIR];
  logic [CODE_W-1:0]       code [NDIR];
  phase_e                  phase;

  assign start    = cmd_on_i | cmd_off_i;
  assign dir_eff  = start ? cmd_on_i : dir_q;
  assign frac_sel = dir_eff ? pre_chg_sel_i : pre_dis_sel_i;
  assign ceil_code = CODE_W'(CODE_TOP) >> ceil_sel_i;
  assign gain     = {1'b0, gain_sel_i} + 3'd1;
  assign err      = $signed({2'b00, meas_dly_i}) - $signed({{(ERR_W-TGT_W){1'b0}}, tgt_dly_i});
  assign init_sel[0] = init_dis_sel_i;
  assign init_sel[1] = init_chg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dir_q <= 1'b1;
    else if (cmd_on_i)  dir_q <= 1'b1;
    else if (cmd_off_i) dir_q <= 1'b0;
  end

  gdr_phase_seq #(.TGT_W(TGT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .tick_i    (tick_i),
    .tgt_i     (tgt_dly_i),
    .frac_i    (frac_sel),
    .post_en_i (post_en_i),
    .phase_o   (phase)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [CODE_W-1:0] init_code;
    assign init_code = CODE_W'(1) << init_sel[d];
    gdr_code_adapt #(
      .CODE_W   (CODE_W),
      .ERR_W    (ERR_W),
      .RST_CODE (d == 1 ? 2 : 4)
    ) u_adapt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .loop_en_i (loop_en_i),
      .upd_i     (meas_vld_i && (dir_q == 1'(d))),
      .full_i    (err_full_i),
      .gain_i    (gain),
      .init_i    (init_code),
      .ceil_i    (ceil_code),
      .err_i     (err),
      .code_o    (code[d])
    );
  end

  assign raw_code = dir_q ? code[1] : code[0];
  assign idrv_o   = (raw_code > ceil_code) ? ceil_code : raw_code;
  assign phase_o  = phase;
  assign dir_o    = dir_q;
endmodule

// File: rtl/gdr_delay_reg_chk.sv
module gdr_delay_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       cmd_on_i,
  input logic       cmd_off_i,
  input logic [1:0] ceil_sel_i,
  input logic       err_full_i,
  input logic       loop_en_i,
  input logic       meas_vld_i,
  input logic [1:0] phase_o,
  input logic       dir_o,
  input logic [4:0] idrv_o
);
  logic [4:0] ceil_lim, prev_code, diff;
  logic [1:0] prev_ceil;
  logic       prev_dir, prev_qual;

  assign ceil_lim = 5'd16 >> ceil_sel_i;
  assign diff     = (idrv_o > prev_code) ? idrv_o - prev_code : prev_code - idrv_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_qual <= 1'b0;
      prev_code <= '0;
      prev_ceil <= '0;
      prev_dir  <= 1'b0;
    end else begin
      prev_qual <= meas_vld_i && loop_en_i && !err_full_i && !cmd_on_i && !cmd_off_i;
      prev_code <= idrv_o;
      prev_ceil <= ceil_sel_i;
      prev_dir  <= dir_o;
    end
  end

  a_r12_code_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idrv_o >= 5'd1) && (idrv_o <= ceil_lim));

  a_r5_phase_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'b11);

  a_r5_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cmd_on_i && !cmd_off_i) |=> $stable(phase_o));

  a_r6_on_sets_charge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_on_i |=> dir_o);

  a_r6_off_sets_discharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_off_i && !cmd_on_i) |=> !dir_o);

  a_r9_step_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_qual && loop_en_i && ceil_sel_i == prev_ceil && dir_o == prev_dir) |-> diff <= 5'd4);
endmodule

bind gdr_delay_reg gdr_delay_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .cmd_on_i   (cmd_on_i),
  .cmd_off_i  (cmd_off_i),
  .ceil_sel_i (ceil_sel_i),
  .err_full_i (err_full_i),
  .loop_en_i  (loop_en_i),
  .meas_vld_i (meas_vld_i),
  .phase_o    (phase_o),
  .dir_o      (dir_o),
  .idrv_o     (idrv_o)
);

// File: tb/gdr_delay_reg_bench.sv
module gdr_delay_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, cmd_on = 0, cmd_off = 0;
  logic [5:0] tgt = 6'd10;
  logic [1:0] fr_chg = 2'b11, fr_dis = 2'b11;
  logic       post_en = 1'b1;
  logic [1:0] in_chg = 2'b01, in_dis = 2'b10, ceil_s = 2'b00, gain_s = 2'b01;
  logic       full = 0, loop_en = 0, mvld = 0;
  logic [7:0] meas = '0;
  logic [1:0] phase;
  logic       dir;
  logic [4:0] idrv;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gdr_delay_reg u_gdr_delay_reg (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_on_i(cmd_on), .cmd_off_i(cmd_off),
    .tgt_dly_i(tgt), .pre_chg_sel_i(fr_chg), .pre_dis_sel_i(fr_dis), .post_en_i(post_en),
    .init_chg_sel_i(in_chg), .init_dis_sel_i(in_dis), .ceil_sel_i(ceil_s),
    .gain_sel_i(gain_s), .err_full_i(full), .loop_en_i(loop_en), .meas_vld_i(mvld),
    .meas_dly_i(meas), .phase_o(phase), .dir_o(dir), .idrv_o(idrv));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_on();
    @(negedge clk) cmd_on = 1;
    @(negedge clk) cmd_on = 0;
  endtask

  task automatic pulse_off();
    @(negedge clk) cmd_off = 1;
    @(negedge clk) cmd_off = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic sample(int m);
    @(negedge clk) begin meas = 8'(m); mvld = 1; end
    @(negedge clk) mvld = 0;
  endtask

  task automatic reload();
    @(negedge clk) loop_en = 0;
    @(negedge clk) loop_en = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 dir", dir, 1);
    chk("R1 R7 idrv", idrv, 2);
  endtask

  // T=10, f=3: P=5, post 5
  task automatic t_pre_post();
    pulse_on();
    chk("R2 enter pre", phase, 1);
    ticks(4);
    chk("R2 pre after 4", phase, 1);
    ticks(1);
    chk("R3 post after 5", phase, 2);
    ticks(4);
    chk("R3 post after 9", phase, 2);
    ticks(1);
    chk("R3 idle after 10", phase, 0);
  endtask

  // f=0: P=1, post 9
  task automatic t_small_frac();
    fr_chg = 2'b00;
    pulse_on();
    chk("R2 short pre", phase, 1);
    ticks(1);
    chk("R2 pre of 1", phase, 2);
    ticks(8);
    chk("R3 post 8", phase, 2);
    ticks(1);
    chk("R3 post 9 idle", phase, 0);
    fr_chg = 2'b11;
  endtask

  task automatic t_post_off();
    post_en = 0;
    pulse_on();
    ticks(4);
    chk("R3 pre no post", phase, 1);
    ticks(1);
    chk("R3 idle no post", phase, 0);
    post_en = 1;
  endtask

  task automatic t_restart();
    pulse_on();
    ticks(3);
    pulse_off();
    chk("R4 restarted pre", phase, 1);
    chk("R6 dir off", dir, 0);
    chk("R6 R7 dis code", idrv, 4);
    ticks(4);
    chk("R4 full pre again", phase, 1);
    ticks(1);
    chk("R4 post after restart", phase, 2);
    ticks(5);
    chk("R4 idle", phase, 0);
  endtask

  task automatic t_no_tick();
    pulse_on();
    repeat (12) @(negedge clk);
    chk("R5 hold no tick", phase, 1);
    ticks(10);
    chk("R5 done", phase, 0);
  endtask

  task automatic t_both_cmd();
    pulse_off();
    @(negedge clk) begin cmd_on = 1; cmd_off = 1; end
    @(negedge clk) begin cmd_on = 0; cmd_off = 0; end
    chk("R6 on wins", dir, 1);
    ticks(10);
  endtask

  task automatic t_loop_off();
    sample(40);
    chk("R8 meas ignored", idrv, 2);
  endtask

  task automatic t_clamped();
    reload();
    sample(14);
    chk("R9 +1*2", idrv, 4);
    sample(30);
    chk("R9 +1*2 big err", idrv, 6);
    sample(10);
    chk("R9 zero err", idrv, 6);
    sample(3);
    chk("R9 -1*2", idrv, 4);
  endtask

  task automatic t_gain();
    gain_s = 2'b11;
    sample(11);
    chk("R11 gain 4", idrv, 8);
    gain_s = 2'b00;
    sample(11);
    chk("R11 gain 1", idrv, 9);
  endtask

  task automatic t_full();
    full = 1;
    sample(12);
    chk("R10 +2", idrv, 11);
    sample(0);
    chk("R10 -10", idrv, 1);
    sample(5);
    chk("R12 floor", idrv, 1);
    gain_s = 2'b11;
    sample(63);
    chk("R12 ceil 16", idrv, 16);
    @(negedge clk) ceil_s = 2'b10;
    #1 chk("R12 ceil 4 immediate", idrv, 4);
    sample(12);
    chk("R12 ceil 4 sat", idrv, 4);
    full = 0;
    ceil_s = 2'b00;
    gain_s = 2'b00;
  endtask

  task automatic t_per_dir();
    reload();
    pulse_off();
    ticks(10);
    sample(20);
    chk("R6 dis adapted", idrv, 5);
    pulse_on();
    chk("R6 chg untouched", idrv, 2);
    ticks(10);
  endtask

  task automatic t_init_ceil();
    @(negedge clk) begin loop_en = 0; in_chg = 2'b11; ceil_s = 2'b11; end
    @(negedge clk);
    chk("R12 init over ceil", idrv, 2);
    @(negedge clk) ceil_s = 2'b00;
    @(negedge clk);
    chk("R7 init 32mA", idrv, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pre_post();
    t_small_frac();
    t_post_off();
    t_restart();
    t_no_tick();
    t_both_cmd();
    t_loop_off();
    t_clamped();
    t_gain();
    t_full();
    t_per_dir();
    t_init_ceil();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule